// File: doc/BRIEF.md
# PCI configuration access port

This block lets a processor on an on-chip register bus run single, non-prefetchable cycles on an external PCI bus. Four word registers hold the target address, a control word (command code, byte enables and status), the write data and the read data. Software fills the address and the control word. For a write it then stores the write data, and that store starts the cycle. For a read, writing a read command into the control word starts the cycle, and software then collects the returned word from the read-data register.

Each cycle uses one address phase and one data phase, followed by a single turnaround clock. The port issues configuration, memory and I/O commands. Configuration cycles always use the Type 0 format. For these cycles, software picks the target by setting exactly one bit in address bits 31 through 11. The port drives that bit out as the IDSEL line of the matching device slot. If no target claims the cycle within five data-phase clocks, the port ends the cycle by itself. It returns all ones for a read and latches a sticky error flag.

Top module: `pci_cfg_port`

## Requirements
- R1: After reset, all four registers read zero, FRAME# and IRDY# are high, the AD output enable is low and no IDSEL line is asserted.
- R2: Register index is bus_addr_i[3:2]: 0 address (read/write), 1 control (read/write), 2 write data (read/write), 3 read data (read-only, writes ignored). Control layout: bits 3:0 command code, bits 7:4 active-low byte enables, bit 8 busy (read-only), bit 9 error.
- R3: A control write whose code has bit 0 clear starts a read cycle. A write-data store while the held code has bit 0 set starts a write cycle. A write-data store while the held code has bit 0 clear starts nothing.
- R4: The address phase lasts exactly one clock with FRAME# low, AD driven and C/BE# carrying the command code. For configuration codes (0xA read, 0xB write), AD[1:0] is forced to 00 and the other bits carry the address. For all other codes, AD carries the address unchanged.
- R5: The data phase follows at once with FRAME# high, IRDY# low and C/BE# carrying the byte enables. Writes drive the write data on AD; reads release AD. The phase ends on the first clock with both DEVSEL# and TRDY# low.
- R6: In the address phase of a configuration cycle, IDSEL line k is asserted only when address bits 31:11 are one-hot with bit 11+k set. No IDSEL line is asserted in any other phase, for other commands, or for a non-one-hot field.
- R7: If DEVSEL# stays high for five data-phase clocks, the cycle ends. A read then stores 0xFFFFFFFF as its result, and the error bit sets.
- R8: The error bit stays set across later cycles until a control write with bit 9 set clears it.
- R9: The read-data register changes only when a read cycle completes, and keeps its value through write cycles.
- R10: Busy reads 1 from the clock after the start until the cycle finishes. While busy, writes to the address, write-data and control fields are ignored.
- R11: After the data phase, one turnaround clock follows with IRDY# high, AD released and busy still set; busy clears on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 4 | Byte offset of the register |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data (combinational) |
| pci_ad_o | output | 32 | AD value driven to the bus |
| pci_ad_oe_o | output | 1 | AD output enable |
| pci_ad_i | input | 32 | AD value sampled from the bus |
| pci_cbe_n_o | output | 4 | Command / byte enables, active low |
| pci_frame_n_o | output | 1 | FRAME#, active low |
| pci_irdy_n_o | output | 1 | IRDY#, active low |
| pci_devsel_n_i | input | 1 | DEVSEL# from the target |
| pci_trdy_n_i | input | 1 | TRDY# from the target |
| pci_idsel_o | output | NDEV (21) | Per-slot IDSEL lines for address bits 31:11 |

## Verification
The checker watches the bus handshake on every clock. It confirms a single-clock address phase that flows straight into the data phase, AD released during read data phases, at most one IDSEL line asserted and only during the address phase, bus activity only while busy, DEVSEL# never awaited past the five-clock window, a stable read-data register outside read completions, and busy covering the turnaround. The bench scenarios cover what the checker cannot see. These are the values carried by each phase (Type 0 address forcing, byte enables, write data), the slot picked by a given address, the all-ones result and sticky error at the exact timeout boundary, the write-1-to-clear error flag, and which register writes start a cycle or are dropped while busy.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned REG_AW = 4;
  localparam int unsigned CODE_W = 4;
  localparam int unsigned BE_W = 4;
  localparam int unsigned BUSY_BIT = 8;
  localparam int unsigned ERR_BIT = 9;

  localparam logic [1:0] IDX_ADDR = 2'd0;
  localparam logic [1:0] IDX_CTRL = 2'd1;
  localparam logic [1:0] IDX_WDAT = 2'd2;
  localparam logic [1:0] IDX_RDAT = 2'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA, ST_TURN} seq_st_e;

  function automatic logic code_is_cfg(input logic [CODE_W-1:0] c);
    return c[3:1] == 3'b101;
  endfunction

  function automatic logic code_is_rd(input logic [CODE_W-1:0] c);
    return ~c[0];
  endfunction
endpackage

// File: rtl/pci_cfg_regs.sv
module pci_cfg_regs
  import pci_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [REG_AW-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  input  logic              busy_i,
  input  logic              rd_cpl_i,
  input  logic              abort_i,
  input  logic [DW-1:0]     rd_data_i,
  output logic [DW-1:0]     addr_o,
  output logic [CODE_W-1:0] code_o,
  output logic [BE_W-1:0]   be_n_o,
  output logic [DW-1:0]     wdata_o,
  output logic [DW-1:0]     rdata_o,
  output logic              err_o,
  output logic              start_o
);
  localparam int unsigned CTRL_USED = ERR_BIT + 1;

  logic [1:0]        idx;
  logic              wr, wr_addr, wr_ctrl, wr_ctrl_ok, wr_wdat;
  logic [DW-1:0]     addr_q, wdata_q, rdata_q;
  logic [CODE_W-1:0] code_q;
  logic [BE_W-1:0]   be_n_q;
  logic              err_q;
  logic              unused_addr;

  assign idx         = bus_addr_i[3:2];
  assign unused_addr = ^bus_addr_i[1:0];
  assign wr          = bus_req_i & bus_we_i;
  assign wr_addr     = wr && idx == IDX_ADDR && !busy_i;
  assign wr_ctrl     = wr && idx == IDX_CTRL;
  assign wr_ctrl_ok  = wr_ctrl && !busy_i;
  assign wr_wdat     = wr && idx == IDX_WDAT && !busy_i;

  assign start_o = (wr_ctrl_ok && code_is_rd(bus_wdata_i[CODE_W-1:0])) ||
                   (wr_wdat && !code_is_rd(code_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      code_q  <= '0;
      be_n_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (wr_addr) addr_q <= bus_wdata_i;
      if (wr_ctrl_ok) begin
        code_q <= bus_wdata_i[CODE_W-1:0];
        be_n_q <= bus_wdata_i[CODE_W +: BE_W];
      end
      if (wr_wdat) wdata_q <= bus_wdata_i;
      if (rd_cpl_i) rdata_q <= rd_data_i;
      // abort wins over a same-cycle clear
      if (abort_i) err_q <= 1'b1;
      else if (wr_ctrl && bus_wdata_i[ERR_BIT]) err_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (idx)
      IDX_ADDR: bus_rdata_o = addr_q;
      IDX_CTRL: bus_rdata_o = {{(DW-CTRL_USED){1'b0}}, err_q, busy_i, be_n_q, code_q};
      IDX_WDAT: bus_rdata_o = wdata_q;
      default:  bus_rdata_o = rdata_q;
    endcase
  end

  assign addr_o  = addr_q;
  assign code_o  = code_q;
  assign be_n_o  = be_n_q;
  assign wdata_o = wdata_q;
  assign rdata_o = rdata_q;
  assign err_o   = err_q;
endmodule

// File: rtl/pci_cfg_idsel.sv
module pci_cfg_idsel #(
  parameter int unsigned NDEV = 21
) (
  input  logic [NDEV-1:0] field_i,
  input  logic            en_i,
  output logic [NDEV-1:0] idsel_o
);
  localparam logic [NDEV-1:0] ONE = {{(NDEV-1){1'b0}}, 1'b1};

  logic one_hot;
  assign one_hot = (field_i != '0) && ((field_i & (field_i - ONE)) == '0);

  for (genvar k = 0; k < NDEV; k++) begin : g_slot
    assign idsel_o[k] = en_i & one_hot & field_i[k];
  end
endmodule

// File: rtl/pci_cfg_seq.sv
module pci_cfg_seq
  import pci_cfg_pkg::*;
#(
  parameter int unsigned TMO = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          rd_i,
  input  logic          devsel_n_i,
  input  logic          trdy_n_i,
  input  logic [DW-1:0] ad_i,
  output seq_st_e       st_o,
  output logic          busy_o,
  output logic          rd_cpl_o,
  output logic          abort_o,
  output logic [DW-1:0] rd_data_o
);
  localparam int unsigned CW = $clog2(TMO + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(TMO - 1);

  seq_st_e       st_q;
  logic [CW-1:0] cnt_q;
  logic          seen_q;
  logic          hit, tmo, in_data;

  assign in_data = st_q == ST_DATA;
  assign hit     = !devsel_n_i && !trdy_n_i;
  assign tmo     = devsel_n_i && !seen_q && cnt_q == CNT_LAST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) st_q <= ST_ADDR;
        ST_ADDR: begin
          st_q   <= ST_DATA;
          cnt_q  <= '0;
          seen_q <= 1'b0;
        end
        ST_DATA: begin
          if (!devsel_n_i) seen_q <= 1'b1;
          else if (!seen_q) cnt_q <= cnt_q + 1'b1;
          if (hit || tmo) st_q <= ST_TURN;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign st_o      = st_q;
  assign busy_o    = st_q != ST_IDLE;
  assign abort_o   = in_data && tmo;
  assign rd_cpl_o  = in_data && rd_i && (hit || tmo);
  assign rd_data_o = tmo ? '1 : ad_i;
endmodule

// File: rtl/pci_cfg_port.sv
module pci_cfg_port
  import pci_cfg_pkg::*;
#(
  parameter int unsigned NDEV    = 21,
  parameter int unsigned SEL_LSB = 11,
  parameter int unsigned TMO     = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [REG_AW-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic [DW-1:0]     pci_ad_o,
  output logic              pci_ad_oe_o,
  input  logic [DW-1:0]     pci_ad_i,
  output logic [BE_W-1:0]   pci_cbe_n_o,
  output logic              pci_frame_n_o,
  output logic              pci_irdy_n_o,
  input  logic              pci_devsel_n_i,
  input  logic              pci_trdy_n_i,
  output logic [NDEV-1:0]   pci_idsel_o
);
  logic [DW-1:0]     addr_q, wdata_q, rdata_q, seq_rd_data, phase_ad;
  logic [CODE_W-1:0] code_q;
  logic [BE_W-1:0]   be_n_q;
  logic              err_q, start, seq_busy, seq_rd_cpl, seq_abort;
  logic              cyc_rd, cyc_cfg;
  seq_st_e           st;

  assign cyc_rd  = code_is_rd(code_q);
  assign cyc_cfg = code_is_cfg(code_q);

  pci_cfg_regs i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_req_i   (bus_req_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .busy_i      (seq_busy),
    .rd_cpl_i    (seq_rd_cpl),
    .abort_i     (seq_abort),
    .rd_data_i   (seq_rd_data),
    .addr_o      (addr_q),
    .code_o      (code_q),
    .be_n_o      (be_n_q),
    .wdata_o     (wdata_q),
    .rdata_o     (rdata_q),
    .err_o       (err_q),
    .start_o     (start)
  );

  pci_cfg_seq #(.TMO(TMO)) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .rd_i       (cyc_rd),
    .devsel_n_i (pci_devsel_n_i),
    .trdy_n_i   (pci_trdy_n_i),
    .ad_i       (pci_ad_i),
    .st_o       (st),
    .busy_o     (seq_busy),
    .rd_cpl_o   (seq_rd_cpl),
    .abort_o    (seq_abort),
    .rd_data_o  (seq_rd_data)
  );

  pci_cfg_idsel #(.NDEV(NDEV)) i_idsel (
    .field_i (addr_q[SEL_LSB +: NDEV]),
    .en_i    (st == ST_ADDR && cyc_cfg),
    .idsel_o (pci_idsel_o)
  );

  // Type 0 configuration: AD[1:0] forced to 00
  assign phase_ad = cyc_cfg ? {addr_q[DW-1:2], 2'b00} : addr_q;

  always_comb begin
    pci_frame_n_o = 1'b1;
    pci_irdy_n_o  = 1'b1;
    pci_ad_oe_o   = 1'b0;
    pci_ad_o      = '0;
    pci_cbe_n_o   = '1;
    unique case (st)
      ST_ADDR: begin
        pci_frame_n_o = 1'b0;
        pci_ad_oe_o   = 1'b1;
        pci_ad_o      = phase_ad;
        pci_cbe_n_o   = code_q;
      end
      ST_DATA: begin
        pci_irdy_n_o = 1'b0;
        pci_ad_oe_o  = !cyc_rd;
        pci_ad_o     = cyc_rd ? '0 : wdata_q;
        pci_cbe_n_o  = be_n_q;
      end
      default: ;
    endcase
  end

  logic unused_err;
  assign unused_err = err_q;
endmodule

// File: rtl/pci_cfg_port_chk.sv
module pci_cfg_port_chk #(
  parameter int unsigned NDEV = 21,
  parameter int unsigned TMO  = 5
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            frame_n,
  input logic            irdy_n,
  input logic            devsel_n,
  input logic            ad_oe,
  input logic [NDEV-1:0] idsel,
  input logic            busy,
  input logic            rd_cpl,
  input logic            rd,
  input logic [31:0]     rdata
);
  localparam int unsigned CW = $clog2(TMO + 2);
  localparam logic [CW-1:0] LIM = CW'(TMO);

  logic [CW-1:0] nodev_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) nodev_q <= '0;
    else if (irdy_n) nodev_q <= '0;
    else if (devsel_n && nodev_q != '1) nodev_q <= nodev_q + 1'b1;
  end

  AST_ADDR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_n |=> frame_n); // R4
  AST_DATA_FOLLOWS_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_n |=> !irdy_n); // R5
  AST_READ_RELEASES_AD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irdy_n && rd) |-> !ad_oe); // R5
  AST_IDSEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(idsel)); // R6
  AST_IDSEL_ADDR_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_n |-> idsel == '0); // R6
  AST_DEVSEL_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irdy_n |-> nodev_q < LIM); // R7
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_cpl |=> $stable(rdata)); // R9
  AST_BUS_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_n || !irdy_n) |-> busy); // R10
  AST_TURN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irdy_n) |-> (busy && !ad_oe)); // R11
endmodule

bind pci_cfg_port pci_cfg_port_chk #(.NDEV(NDEV), .TMO(TMO)) i_pci_cfg_port_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .frame_n  (pci_frame_n_o),
  .irdy_n   (pci_irdy_n_o),
  .devsel_n (pci_devsel_n_i),
  .ad_oe    (pci_ad_oe_o),
  .idsel    (pci_idsel_o),
  .busy     (seq_busy),
  .rd_cpl   (seq_rd_cpl),
  .rd       (cyc_rd),
  .rdata    (rdata_q)
);

// File: tb/test_pci_cfg_port.sv
`timescale 1ns/1ps
module test_pci_cfg_port;
  localparam int NDEV = 21;
  localparam int TGT  = 3;
  localparam logic [31:0] MASK = 32'h5A5A_0F0F;
  localparam int NVEC = 8;
  // {code, be_n, addr, wdata, lat, abort}
  localparam logic [76:0] VEC [NVEC] = '{
    {4'hA, 4'h0, 32'h0000_4008, 32'h0000_0000, 4'd0, 1'b0},
    {4'hB, 4'h0, 32'h0000_4010, 32'hDEAD_BEEF, 4'd2, 1'b0},
    {4'h6, 4'hC, 32'h8000_1234, 32'h0000_0000, 4'd1, 1'b0},
    {4'h7, 4'h5, 32'h8000_2000, 32'h1234_5678, 4'd3, 1'b0},
    {4'h2, 4'hE, 32'h0000_0103, 32'h0000_0000, 4'd4, 1'b0},
    {4'h3, 4'h0, 32'h0000_0200, 32'hA5A5_5A5A, 4'd0, 1'b0},
    {4'hA, 4'h0, 32'h0001_0000, 32'h0000_0000, 4'd0, 1'b1},
    {4'hA, 4'h0, 32'h0000_4003, 32'h0000_0000, 4'd0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] ad_o, ad_i;
  logic ad_oe, frame_n, irdy_n, devsel_n, trdy_n;
  logic [3:0] cbe_n;
  logic [NDEV-1:0] idsel;

  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  pci_cfg_port i_pci_cfg_port (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_req_i(bus_req), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .pci_ad_o(ad_o), .pci_ad_oe_o(ad_oe), .pci_ad_i(ad_i),
    .pci_cbe_n_o(cbe_n), .pci_frame_n_o(frame_n), .pci_irdy_n_o(irdy_n),
    .pci_devsel_n_i(devsel_n), .pci_trdy_n_i(trdy_n), .pci_idsel_o(idsel)
  );

  // target model: claims memory/I/O always, configuration only on slot TGT
  logic [31:0] cap_addr = '0, cap_wdata = '0;
  logic [3:0]  cap_cmd = '0, cap_be = '0;
  logic [NDEV-1:0] cap_idsel = '0;
  logic hit_q = 1'b0;
  int dcnt = 0, lat = 0, naddr = 0, ncpl = 0;

  always @(posedge clk) begin
    if (!frame_n) begin
      cap_addr  <= ad_o;
      cap_cmd   <= cbe_n;
      cap_idsel <= idsel;
      hit_q     <= (cbe_n[3:1] == 3'b101) ? idsel[TGT] : 1'b1;
      dcnt      <= 0;
      naddr     <= naddr + 1;
    end else if (!irdy_n) begin
      dcnt <= dcnt + 1;
      if (!devsel_n && !trdy_n) begin
        cap_wdata <= ad_o;
        cap_be    <= cbe_n;
        ncpl      <= ncpl + 1;
      end
    end
  end
  assign devsel_n = !(hit_q && !irdy_n && dcnt >= lat);
  assign trdy_n   = devsel_n;
  assign ad_i     = cap_addr ^ MASK;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 60; i++) begin
      bus_rd(4'h4, v);
      if (!v[8]) break;
      @(negedge clk);
    end
  endtask

  task automatic run_txn(input logic [3:0] code, input logic [3:0] be,
                         input logic [31:0] addr, input logic [31:0] wd);
    bus_wr(4'h0, addr);
    bus_wr(4'h4, {24'h0, be, code});
    if (code[0]) bus_wr(4'h8, wd);
    wait_idle();
  endtask

  function automatic logic [NDEV-1:0] exp_idsel(input logic [3:0] c, input logic [31:0] a);
    if (c[3:1] == 3'b101 && $onehot(a[31:11])) return a[31:11];
    return '0;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, saved;
    int n0;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int r = 0; r < 4; r++) begin
      bus_rd(4'(r * 4), v);
      check("R1 reg", v, 32'h0);
    end
    check("R1 pins", {28'h0, frame_n, irdy_n, ad_oe, |idsel}, 32'hC);
    rst_n = 1'b1;

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [3:0] c, be;
      logic [31:0] a, wd, ead;
      logic abt;
      {c, be, a, wd} = VEC[i][76:5];
      lat = int'(VEC[i][4:1]);
      abt = VEC[i][0];
      ead = (c[3:1] == 3'b101) ? {a[31:2], 2'b00} : a;
      run_txn(c, be, a, wd);
      check("R4 addr phase AD", cap_addr, ead);
      check("R4 command", {28'h0, cap_cmd}, {28'h0, c});
      check("R6 idsel", 32'(cap_idsel), 32'(exp_idsel(c, a)));
      if (c[0]) begin
        check("R5 write data", cap_wdata, wd);
        check("R5 byte enables", {28'h0, cap_be}, {28'h0, be});
      end else begin
        bus_rd(4'hC, v);
        check(abt ? "R7 abort data" : "R5 read data", v, abt ? 32'hFFFF_FFFF : ead ^ MASK);
      end
      bus_rd(4'h4, v);
      check("R7 error bit", {31'h0, v[9]}, {31'h0, abt});
      if (abt) bus_wr(4'h4, 32'h0000_0207);
    end

    // R2 register readback and read-only read data
    bus_wr(4'h0, 32'h1234_5678); bus_rd(4'h0, v);
    check("R2 address reg", v, 32'h1234_5678);
    bus_wr(4'h8, 32'h0BAD_F00D); bus_rd(4'h8, v);
    check("R2 wdata reg", v, 32'h0BAD_F00D);
    bus_rd(4'hC, saved);
    bus_wr(4'hC, 32'hCAFE_0000); bus_rd(4'hC, v);
    check("R2 rdata read-only", v, saved);
    n0 = naddr;
    bus_wr(4'h4, 32'h0000_00B5); bus_rd(4'h4, v);
    check("R2 ctrl fields", {24'h0, v[7:0]}, 32'hB5);
    check("R3 odd code no start", 32'(naddr - n0), 32'h0);

    // R11 / R4 / R5 cycle timing, read with immediate claim
    lat = 0;
    bus_wr(4'h0, 32'h8000_0000);
    bus_wr(4'h4, 32'h0000_0006);
    check("R4 frame low", {31'h0, frame_n}, 32'h0);
    @(negedge clk);
    check("R5 data phase", {30'h0, frame_n, irdy_n}, 32'h2);
    @(negedge clk);
    bus_rd(4'h4, v);
    check("R11 turnaround", {29'h0, irdy_n, ad_oe, v[8]}, 32'h5);
    @(negedge clk);
    bus_rd(4'h4, v);
    check("R11 idle", {31'h0, v[8]}, 32'h0);

    // R3 write-data store with read code held: no cycle
    n0 = naddr;
    bus_wr(4'h8, 32'h7777_7777);
    repeat (6) @(negedge clk);
    check("R3 wdata with read code", 32'(naddr - n0), 32'h0);

    // R10 writes ignored while busy
    lat = 3;
    bus_wr(4'h0, 32'h8000_0040);
    bus_wr(4'h4, 32'h0000_0006);
    bus_rd(4'h4, v);
    check("R10 busy set", {31'h0, v[8]}, 32'h1);
    bus_wr(4'h0, 32'hFFFF_0000);
    wait_idle();
    bus_rd(4'h0, v);
    check("R10 addr write dropped", v, 32'h8000_0040);

    // R7 boundary: DEVSEL# too late -> abort
    lat = 5;
    run_txn(4'h6, 4'h0, 32'h8000_0080, 32'h0);
    bus_rd(4'hC, v);
    check("R7 late devsel data", v, 32'hFFFF_FFFF);
    // R6 non-one-hot select: no IDSEL, aborts
    lat = 0;
    run_txn(4'hA, 4'h0, 32'h0000_4800, 32'h0);
    check("R6 non-onehot idsel", 32'(cap_idsel), 32'h0);
    bus_rd(4'hC, v);
    check("R7 unclaimed cfg", v, 32'hFFFF_FFFF);
    // R8 sticky across good cycle, then W1C
    run_txn(4'h6, 4'h0, 32'h8000_00C0, 32'h0);
    bus_rd(4'h4, v);
    check("R8 sticky error", {31'h0, v[9]}, 32'h1);
    bus_wr(4'h4, 32'h0000_0207);
    bus_rd(4'h4, v);
    check("R8 W1C clear", {31'h0, v[9]}, 32'h0);

    // R9 read data held over write cycle
    bus_rd(4'hC, saved);
    check("R9 last read", saved, 32'h8000_00C0 ^ MASK);
    run_txn(4'h7, 4'h0, 32'h8000_0100, 32'h1111_2222);
    bus_rd(4'hC, v);
    check("R9 hold over write", v, saved);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule